// File: doc/BRIEF.md
# Change-of-Flow Target Buffer

This block is a small, fully associative store of instruction words kept by the fetch target they belong to. When the core redirects fetch, it presents the new address with a valid strobe. The buffer compares that address with every stored tag in the same cycle. On a match it returns, combinationally, the instruction words held for that target, together with a per-word valid mask, so the fetch unit can issue them while the memory request is still outstanding.

On a miss the buffer claims an entry with no help from software. Victims are taken in round-robin order. The new tag is written and the words of the following fill beats are captured in order as the memory returns them.

Three control inputs set how the buffer behaves. An enable turns the whole structure on or off. An inhibit suppresses hits and allocation but lets a fill already in flight finish. A flush empties every entry in one cycle. Branch direction prediction and the memory fetch itself are outside this block.

Top module: `cof_target_buffer`

## Requirements
- R1: After synchronous reset every entry is empty, `hit` is 0, `hit_word_valid` and `hit_data` are all zero, and the round-robin victim pointer is at entry 0.
- R2: A lookup happens in a cycle with `cof_valid`=1, `ctl_enable`=1, `ctl_inhibit`=0 and `ctl_flush`=0. The tag is `cof_addr[31:2]`, and it is compared with all eight stored tags. `hit` rises combinationally in that same cycle, and address bits [1:0] take no part in the match.
- R3: On a hit, word k of the entry appears on `hit_data[32k+31:32k]`, and `hit_word_valid[k]` is 1 exactly when word k has been filled. A word that is not valid reads as zero. With no hit, all three outputs are zero.
- R4: A lookup that misses allocates the entry at the victim pointer. Victims go 0,1,…,7 and then wrap to 0. The entry's tag is written and all its words become invalid. A fill beat presented in the allocation cycle is ignored.
- R5: After an allocation, each cycle with `fill_valid`=1 writes `fill_data` into the next word, in the order 0,1,2,3. Beats after the fourth are ignored. A new miss abandons the unfinished fill and restarts at word 0 of the new victim.
- R6: With `ctl_inhibit`=1 (and enable on), `hit` stays 0 and no entry is allocated. Stored contents are kept, and a fill already in progress keeps accepting beats.
- R7: With `ctl_enable`=0, `hit` stays 0, nothing is allocated and contents are kept. Any fill in progress is abandoned, so its later beats are ignored even after the buffer is enabled again.
- R8: `ctl_flush`=1 empties all entries in that single cycle, whatever the enable and inhibit state. It overrides a fill beat and a lookup in the same cycle: no hit is reported and nothing is allocated. It leaves the victim pointer where it was.
- R9: At most one entry ever matches a lookup. A repeated lookup of a stored target hits the same entry and allocates nothing new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Buffer on (1) or off (0) |
| ctl_inhibit | input | 1 | Suppress hits and allocation, keep contents |
| ctl_flush | input | 1 | Invalidate every entry this cycle |
| cof_valid | input | 1 | Change-of-flow address valid |
| cof_addr | input | 32 | Change-of-flow fetch address |
| fill_valid | input | 1 | Fill beat valid |
| fill_data | input | 32 | Fill beat instruction word |
| hit | output | 1 | Lookup matched a stored tag |
| hit_word_valid | output | 4 | Per-word valid mask of the matching entry |
| hit_data | output | 128 | Instruction words of the matching entry, word 0 in the low bits |

## Verification
A behavioural model in the bench predicts hit, mask and data every cycle across several traffic patterns. The first is a cold miss followed by gapped fill beats, with a lookup in the middle of the fill; this separates partial valid masks from full ones. The second is a run of nine distinct misses that wraps the victim pointer, which shows whether replacement follows round-robin order and evicts the oldest entry. Further runs lay an interrupting miss, inhibit, disable and flush over a fill in flight. These tell apart the three control modes by whether the unfinished fill survives, and they confirm that a flush overrides a same-cycle lookup and fill beat.

// File: rtl/cof_btb_pkg.sv
`timescale 1ns/1ps
package cof_btb_pkg;
  // State of the fill cursor that tracks incoming fetch beats
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cof_btb_tags.sv
`timescale 1ns/1ps
module cof_btb_tags #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 30,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               alloc_we,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic [TAG_W-1:0]   look_tag,
  output logic [ENTRIES-1:0] match_vec
);
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ENTRIES-1:0] tag_vld;

  // Tag storage: plain write port, no reset, suits distributed RAM
  always_ff @(posedge clk) begin
    if (alloc_we) tag_mem[alloc_idx] <= alloc_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      tag_vld <= '0;
    end else if (alloc_we) begin
      tag_vld[alloc_idx] <= 1'b1;
    end
  end

  // One comparator per entry, all in parallel
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = tag_vld[e] && (tag_mem[e] == look_tag);
  end

  // R9: allocation only on a miss, so never two matching entries
  p_one_match_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R8: a flush leaves nothing that can match
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (match_vec == '0));
endmodule

// File: rtl/cof_btb_words.sv
`timescale 1ns/1ps
module cof_btb_words #(
  parameter int ENTRIES = 8,
  parameter int WORDS   = 4,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SLOTS  = ENTRIES * WORDS,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    clr_we,
  input  logic [IDX_W-1:0]        clr_idx,
  input  logic                    wr_we,
  input  logic [IDX_W-1:0]        wr_entry,
  input  logic [WIDX_W-1:0]       wr_word,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [IDX_W-1:0]        rd_entry,
  output logic [WORDS*DATA_W-1:0] rd_words,
  output logic [WORDS-1:0]        rd_vld
);
  logic [DATA_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0]  slot_vld;
  logic [SLOT_W-1:0] wr_slot;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [IDX_W-1:0] ent, input int wd);
    return SLOT_W'(int'(ent) * WORDS + wd);
  endfunction

  assign wr_slot = slot_of(wr_entry, int'(wr_word));

  // Single write port, word-wide
  always_ff @(posedge clk) begin
    if (wr_we) mem[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      slot_vld <= '0;
    end else begin
      if (clr_we) begin
        for (int w = 0; w < WORDS; w++) slot_vld[slot_of(clr_idx, w)] <= 1'b0;
      end
      if (wr_we) slot_vld[wr_slot] <= 1'b1;
    end
  end

  // Read all words of one entry; an invalid word is forced to zero
  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    logic [SLOT_W-1:0] rd_slot;
    assign rd_slot = slot_of(rd_entry, w);
    assign rd_vld[w] = slot_vld[rd_slot];
    assign rd_words[w*DATA_W +: DATA_W] = rd_vld[w] ? mem[rd_slot] : '0;
  end

  // R5: a written word is valid on the next cycle
  p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_we && !flush && !clr_we) |=> slot_vld[$past(wr_slot)]);

  // R8: flush empties every word
  p_flush_words_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (slot_vld == '0));
endmodule

// File: rtl/cof_btb_fill_ctl.sv
`timescale 1ns/1ps
module cof_btb_fill_ctl
  import cof_btb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WORDS   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              enable,
  input  logic              alloc,
  input  logic              fill_valid,
  output logic [IDX_W-1:0]  victim,
  output logic              fill_we,
  output logic [IDX_W-1:0]  fill_entry,
  output logic [WIDX_W-1:0] fill_word
);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [WIDX_W-1:0] LAST_WD  = WIDX_W'(WORDS - 1);

  fill_state_e      st;
  logic [IDX_W-1:0] rr_ptr;

  assign victim  = rr_ptr;
  // An allocation cycle discards any beat; flush and disable cancel it too
  assign fill_we = (st == FILL_BUSY) && fill_valid && enable && !flush && !alloc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= FILL_IDLE;
      rr_ptr     <= '0;
      fill_entry <= '0;
      fill_word  <= '0;
    end else if (flush || !enable) begin
      st <= FILL_IDLE;
    end else if (alloc) begin
      rr_ptr     <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
      st         <= FILL_BUSY;
      fill_entry <= rr_ptr;
      fill_word  <= '0;
    end else if (fill_we) begin
      if (fill_word == LAST_WD) st <= FILL_IDLE;
      else                      fill_word <= fill_word + 1'b1;
    end
  end

  // R8: flush never moves the victim pointer
  p_flush_keeps_ptr_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> $stable(victim));

  // R7: disabling abandons any fill in flight
  p_disable_stops_fill_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (st == FILL_IDLE));

  // R4/R5: an allocation aims the fill at word 0 of the old victim
  p_alloc_starts_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (alloc && enable && !flush) |=>
      (st == FILL_BUSY && fill_word == '0 && fill_entry == $past(victim)));
endmodule

// File: rtl/cof_target_buffer.sv
`timescale 1ns/1ps
module cof_target_buffer #(
  parameter int ENTRIES = 8,
  parameter int WORDS   = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctl_enable,
  input  logic                    ctl_inhibit,
  input  logic                    ctl_flush,
  input  logic                    cof_valid,
  input  logic [ADDR_W-1:0]       cof_addr,
  input  logic                    fill_valid,
  input  logic [DATA_W-1:0]       fill_data,
  output logic                    hit,
  output logic [WORDS-1:0]        hit_word_valid,
  output logic [WORDS*DATA_W-1:0] hit_data
);
  logic [TAG_W-1:0]        look_tag;
  logic [ENTRIES-1:0]      match_vec;
  logic                    any_match;
  logic                    lookup_en;
  logic                    alloc;
  logic [IDX_W-1:0]        hit_idx;
  logic [IDX_W-1:0]        victim;
  logic                    fill_we;
  logic [IDX_W-1:0]        fill_entry;
  logic [WIDX_W-1:0]       fill_word;
  logic [WORDS*DATA_W-1:0] rd_words;
  logic [WORDS-1:0]        rd_vld;
  logic                    unused_offset;

  assign look_tag      = cof_addr[ADDR_W-1:OFF_W];
  assign unused_offset = ^cof_addr[OFF_W-1:0];

  assign lookup_en = cof_valid && ctl_enable && !ctl_inhibit && !ctl_flush;
  assign any_match = |match_vec;
  assign hit       = lookup_en && any_match;
  assign alloc     = lookup_en && !any_match;

  // One-hot to index by OR-reduction: valid since at most one bit is set
  always_comb begin
    hit_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_vec[e]) hit_idx = hit_idx | IDX_W'(e);
    end
  end

  cof_btb_tags #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .flush     (ctl_flush),
    .alloc_we  (alloc),
    .alloc_idx (victim),
    .alloc_tag (look_tag),
    .look_tag  (look_tag),
    .match_vec (match_vec)
  );

  cof_btb_fill_ctl #(.ENTRIES(ENTRIES), .WORDS(WORDS)) u_fill (
    .clk        (clk),
    .rst        (rst),
    .flush      (ctl_flush),
    .enable     (ctl_enable),
    .alloc      (alloc),
    .fill_valid (fill_valid),
    .victim     (victim),
    .fill_we    (fill_we),
    .fill_entry (fill_entry),
    .fill_word  (fill_word)
  );

  cof_btb_words #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W)) u_words (
    .clk      (clk),
    .rst      (rst),
    .flush    (ctl_flush),
    .clr_we   (alloc),
    .clr_idx  (victim),
    .wr_we    (fill_we),
    .wr_entry (fill_entry),
    .wr_word  (fill_word),
    .wr_data  (fill_data),
    .rd_entry (hit_idx),
    .rd_words (rd_words),
    .rd_vld   (rd_vld)
  );

  assign hit_word_valid = hit ? rd_vld   : '0;
  assign hit_data       = hit ? rd_words : '0;

  // R6/R7/R8: no hit unless a lookup is allowed this cycle
  p_no_hit_when_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctl_enable || ctl_inhibit || ctl_flush || !cof_valid) |-> !hit);

  // R3: words not marked valid read as zero
  for (genvar w = 0; w < WORDS; w++) begin : g_chk
    p_invalid_word_zero_r3: assert property (@(posedge clk) disable iff (rst)
      !hit_word_valid[w] |-> (hit_data[w*DATA_W +: DATA_W] == '0));
  end
endmodule

// File: tb/cof_target_buffer_tb.sv
`timescale 1ns/1ps
module cof_target_buffer_tb_top;
  localparam int  NE = 8;
  localparam int  NW = 4;
  localparam time CLK_PERIOD = 20ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctl_enable = 1'b0, ctl_inhibit = 1'b0, ctl_flush = 1'b0;
  logic         cof_valid = 1'b0, fill_valid = 1'b0;
  logic [31:0]  cof_addr = '0, fill_data = '0;
  logic         hit;
  logic [3:0]   hit_word_valid;
  logic [127:0] hit_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cof_target_buffer dut_i (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_inhibit(ctl_inhibit),
    .ctl_flush(ctl_flush), .cof_valid(cof_valid), .cof_addr(cof_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .hit(hit),
    .hit_word_valid(hit_word_valid), .hit_data(hit_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [29:0] m_tag [NE];
  bit          m_tv  [NE];
  logic [31:0] m_w   [NE][NW];
  bit          m_wv  [NE][NW];
  int          m_rr = 0, m_fe = 0, m_fw = 0;
  bit          m_busy = 0;

  function automatic void chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] ad(int i);
    return 32'h1000_0000 + 32'(i) * 32'h40;
  endfunction

  task automatic cyc(string req, bit cv, logic [31:0] a, bit fv, logic [31:0] d,
                     bit en, bit inh, bit fl);
    bit           lk, eh;
    int           ei;
    logic [3:0]   ewv;
    logic [127:0] ed;
    cof_valid = cv; cof_addr = a; fill_valid = fv; fill_data = d;
    ctl_enable = en; ctl_inhibit = inh; ctl_flush = fl;
    #2;
    lk = cv && en && !inh && !fl;
    eh = 0; ei = 0; ewv = '0; ed = '0;
    if (lk) begin
      for (int e = 0; e < NE; e++)
        if (m_tv[e] && m_tag[e] == a[31:2]) begin eh = 1; ei = e; end
    end
    if (eh) begin
      for (int k = 0; k < NW; k++) begin
        ewv[k] = m_wv[ei][k];
        if (m_wv[ei][k]) ed[32*k +: 32] = m_w[ei][k];
      end
    end
    chk(req, "hit", 128'(hit), 128'(eh));
    chk(req, "hit_word_valid", 128'(hit_word_valid), 128'(ewv));
    chk(req, "hit_data", hit_data, ed);
    @(posedge clk);
    if (fl) begin
      for (int e = 0; e < NE; e++) begin
        m_tv[e] = 0;
        for (int k = 0; k < NW; k++) m_wv[e][k] = 0;
      end
      m_busy = 0;
    end else if (!en) begin
      m_busy = 0;
    end else if (lk && !eh) begin
      m_tag[m_rr] = a[31:2];
      m_tv[m_rr]  = 1;
      for (int k = 0; k < NW; k++) m_wv[m_rr][k] = 0;
      m_busy = 1; m_fe = m_rr; m_fw = 0;
      m_rr = (m_rr + 1) % NE;
    end else if (m_busy && fv) begin
      m_w[m_fe][m_fw]  = d;
      m_wv[m_fe][m_fw] = 1;
      m_fw++;
      if (m_fw == NW) m_busy = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_tv[e] = 0;
      for (int k = 0; k < NW; k++) begin m_wv[e][k] = 0; m_w[e][k] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle while reset is held
    chk("R1", "hit in reset", 128'(hit), 128'(0));
    rst = 1'b0;
    cyc("R1", 0, 32'h0, 0, 32'h0, 1, 0, 0);
    cyc("R1", 1, ad(0), 0, 32'h0, 0, 0, 0);     // disabled, empty buffer

    // R4: miss allocates entry 0; beat in the same cycle is dropped
    cyc("R4", 1, ad(0), 1, 32'hDEAD_0000, 1, 0, 0);
    // R5: gapped fill beats
    cyc("R5", 0, 32'h0, 1, 32'hA000_0000, 1, 0, 0);
    cyc("R5", 0, 32'h0, 0, 32'hFFFF_FFFF, 1, 0, 0);
    cyc("R5", 0, 32'h0, 1, 32'hA000_0001, 1, 0, 0);
    // R3: hit mid-fill shows two valid words; R2: low address bits ignored
    cyc("R3", 1, ad(0) | 32'h2, 0, 32'h0, 1, 0, 0);
    cyc("R5", 0, 32'h0, 1, 32'hA000_0002, 1, 0, 0);
    cyc("R5", 0, 32'h0, 1, 32'hA000_0003, 1, 0, 0);
    cyc("R5", 0, 32'h0, 1, 32'hBAD0_BAD0, 1, 0, 0);  // fifth beat ignored
    cyc("R2", 1, ad(0) | 32'h3, 0, 32'h0, 1, 0, 0);
    // R9: repeated lookups of the same target keep hitting, no new entry
    cyc("R9", 1, ad(0), 1, 32'h1111_1111, 1, 0, 0);
    cyc("R9", 1, ad(0), 0, 32'h0, 1, 0, 0);
    cyc("R2", 1, ad(0) + 32'h4, 0, 32'h0, 1, 0, 0);  // next word address: miss, entry 1

    // R4: fill entries up to wrap-around, one beat each
    for (int i = 1; i <= 8; i++) begin
      cyc("R4", 1, ad(i), 0, 32'h0, 1, 0, 0);
      cyc("R4", 0, 32'h0, 1, 32'hC000_0000 + 32'(i), 1, 0, 0);
    end
    cyc("R4", 1, ad(0), 0, 32'h0, 1, 0, 0);   // evicted earlier, misses again
    cyc("R4", 1, ad(8), 0, 32'h0, 1, 0, 0);

    // R5: a new miss restarts the fill on another victim
    cyc("R5", 1, ad(9), 0, 32'h0, 1, 0, 0);
    cyc("R5", 0, 32'h0, 1, 32'hD900_0000, 1, 0, 0);
    cyc("R5", 1, ad(10), 1, 32'hEEEE_EEEE, 1, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R5", 0, 32'h0, 1, 32'hDA00_0000 + 32'(k), 1, 0, 0);
    cyc("R5", 1, ad(9), 0, 32'h0, 1, 0, 0);
    cyc("R5", 1, ad(10), 0, 32'h0, 1, 0, 0);

    // R6: inhibit suppresses hits and allocation but lets the fill finish
    cyc("R6", 1, ad(11), 0, 32'h0, 1, 0, 0);
    cyc("R6", 0, 32'h0, 1, 32'hE100_0000, 1, 0, 0);
    cyc("R6", 1, ad(11), 1, 32'hE100_0001, 1, 1, 0);
    cyc("R6", 1, ad(20), 1, 32'hE100_0002, 1, 1, 0);
    cyc("R6", 1, ad(10), 0, 32'h0, 1, 1, 0);
    cyc("R6", 1, ad(11), 0, 32'h0, 1, 0, 0);
    cyc("R6", 1, ad(20), 0, 32'h0, 1, 0, 0);   // was not allocated: misses now

    // R7: disable abandons the fill; contents survive
    cyc("R7", 1, ad(12), 0, 32'h0, 1, 0, 0);
    cyc("R7", 0, 32'h0, 1, 32'hF200_0000, 1, 0, 0);
    cyc("R7", 1, ad(12), 1, 32'hF200_0001, 0, 0, 0);
    cyc("R7", 1, ad(30), 0, 32'h0, 0, 0, 0);
    cyc("R7", 0, 32'h0, 1, 32'hF200_0002, 1, 0, 0);
    cyc("R7", 1, ad(12), 0, 32'h0, 1, 0, 0);
    cyc("R7", 1, ad(10), 0, 32'h0, 1, 0, 0);

    // R8: flush with a same-cycle lookup and fill beat, while disabled too
    cyc("R8", 1, ad(13), 0, 32'h0, 1, 0, 0);
    cyc("R8", 1, ad(10), 1, 32'h9999_9999, 1, 0, 1);
    cyc("R8", 1, ad(10), 0, 32'h0, 1, 0, 0);
    cyc("R8", 0, 32'h0, 1, 32'h8888_8888, 1, 0, 0);
    cyc("R8", 1, ad(10), 0, 32'h0, 1, 0, 0);
    cyc("R8", 0, 32'h0, 0, 32'h0, 0, 0, 1);
    cyc("R8", 1, ad(10), 0, 32'h0, 1, 0, 0);
    for (int i = 40; i < 50; i++) begin
      cyc("R8", 1, ad(i), 0, 32'h0, 1, 0, 0);
      cyc("R8", 0, 32'h0, 1, 32'h7700_0000 + 32'(i), 1, 0, 0);
    end
    for (int i = 40; i < 50; i++) cyc("R9", 1, ad(i), 0, 32'h0, 1, 0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule